// File: doc/BRIEF.md
# Phase-Continuous Tristate FSK Sequencer

This block produces a two-tone frequency-shift-keyed signal as a stepped sine wave. It uses no phase accumulator and no sample table. Three drive lines leave the block. Each line is meant to feed its own resistor, sized so that the current through it is proportional to the sine of 30°, 60° or 90°. A shared drive level sets the sign of that current. Lines that are not enabled float. An external summing stage and lowpass filter turn the stepped waveform into a smooth tone. Those parts, and any framing of the bit stream, lie outside this block.

A twelve-step phase index walks the sine cycle. Each step lasts a whole number of clock cycles. That number is reloaded at the end of every step from one of two parameter-derived intervals, chosen by the serial data input. The data bit is therefore re-examined at each step boundary. A change of data alters the tone from the next step onward. The phase index is never disturbed, so the waveform stays continuous across the change. A one-cycle strobe marks the start of every sine cycle.

Top module: `fsk_tristate_sequencer`

## Requirements
- R1: While reset is high, and on the cycle after it, all line enables are 0, the drive level is 1 and the cycle strobe is 0.
- R2: The enable pattern for steps 0 to 5 is 000, 001, 010, 100, 010, 001 (bit 0 = 30° line, bit 1 = 60° line, bit 2 = 90° line), with the drive level 1.
- R3: Steps 6 to 11 repeat the enable pattern of R2 with the drive level 0. The level changes only on a step whose enables are all 0.
- R4: In every cycle, at most one of the three enables is 1.
- R5: While the data input is 1, every step lasts round(CLK_HZ / (12·MARK_HZ)) cycles (19 at the test clock setting), so a full cycle lasts 12 times that.
- R6: While the data input is 0, every step lasts round(CLK_HZ / (12·SPACE_HZ)) cycles (10 at the test clock setting).
- R7: The data input is sampled on the last cycle of each step. A change in the middle of a step leaves that step's length unchanged and sets the length of the next step. The step sequence carries on from where it was, without restarting.
- R8: After reset is released, step 0 is shown for one interval plus one cycle, and that interval is chosen by the data value present during reset. The following steps then run normally.
- R9: The cycle strobe is high for exactly one cycle, on the cycle where step 0 first appears on the outputs. It does not fire at reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 1 | Serial data bit; 1 selects the mark tone, 0 the space tone |
| line_en_o | output | 3 | Per-line output enables (bit 0 = 30°, bit 1 = 60°, bit 2 = 90° weight) |
| drive_lvl_o | output | 1 | Shared drive level for the enabled line: 1 for the positive half, 0 for the negative |
| wrap_o | output | 1 | One-cycle strobe at the start of each sine cycle |

## Verification
The bench flips the data input partway through a step. A design that resamples the data every cycle would stretch or shrink the current step. A design that resets the phase on a data change would jump back to step 0 instead of moving to the next pattern. The bench checks where the drive level flips and the full twelve-step pattern. A decoder with an off-by-one would change the level on a nonzero step, or drive two lines at once. The bench also applies reset in the middle of a tone with the opposite data value. The first step must then use the interval chosen during reset, and the strobe must stay quiet at release. A design that loaded a stale interval, or pulsed the strobe on leaving reset, would fail there.

// File: rtl/fsk_seq_pkg.sv
package fsk_seq_pkg;
  localparam int STEPS = 12;
  localparam int HALF  = STEPS / 2;
  localparam int PH_W  = 4;

  typedef logic [PH_W-1:0] phase_t;
  typedef logic [2:0]      line_vec_t;

  // position within a half cycle: 0 is the zero sample, 3 the peak
  function automatic phase_t half_pos(phase_t ph);
    if (ph >= PH_W'(HALF)) return ph - PH_W'(HALF);
    return ph;
  endfunction

  function automatic line_vec_t lines_for(phase_t ph);
    line_vec_t v;
    case (half_pos(ph))
      PH_W'(1), PH_W'(5): v = 3'b001;
      PH_W'(2), PH_W'(4): v = 3'b010;
      PH_W'(3):           v = 3'b100;
      default:            v = 3'b000;
    endcase
    return v;
  endfunction

  function automatic logic level_for(phase_t ph);
    return ph < PH_W'(HALF);
  endfunction
endpackage

// File: rtl/fsk_step_timer.sv
module fsk_step_timer #(
  parameter int MARK_RELOAD  = 19,
  parameter int SPACE_RELOAD = 10,
  parameter int CNT_W        = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic data_i,
  output logic step_adv_o
);
  localparam logic [CNT_W-1:0] MARK_LAST  = CNT_W'(MARK_RELOAD - 1);
  localparam logic [CNT_W-1:0] SPACE_LAST = CNT_W'(SPACE_RELOAD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val   = data_i ? MARK_LAST : SPACE_LAST;
  assign step_adv_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= load_val;
    else if (step_adv_o)  cnt_q <= load_val;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  // R5: a mark sample at a step boundary loads the mark interval
  p_mark_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (step_adv_o && data_i) |=> (cnt_q == MARK_LAST));

  // R6: a space sample at a step boundary loads the space interval
  p_space_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (step_adv_o && !data_i) |=> (cnt_q == SPACE_LAST));

  // R7: within a step the count only moves down by one, whatever data does
  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    !step_adv_o |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fsk_phase_walk.sv
module fsk_phase_walk
  import fsk_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv_i,
  output phase_t phase_o
);
  localparam phase_t LAST = PH_W'(STEPS - 1);

  phase_t phase_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst)              phase_q <= '0;
    else if (adv_i)       phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  // R2: the index stays within the twelve steps
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST);

  // R2: the last step wraps to step 0
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (adv_i && phase_q == LAST) |=> (phase_q == '0));

  // R7: without a step boundary the index never moves (no reset on data change)
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(phase_q));
endmodule

// File: rtl/fsk_line_drive.sv
module fsk_line_drive
  import fsk_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  phase_t    phase_i,
  input  logic      adv_i,
  output line_vec_t line_en_o,
  output logic      drive_lvl_o,
  output logic      wrap_o
);
  logic adv_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_d       <= 1'b0;
      line_en_o   <= '0;
      drive_lvl_o <= 1'b1;
      wrap_o      <= 1'b0;
    end else begin
      adv_d       <= adv_i;
      line_en_o   <= lines_for(phase_i);
      drive_lvl_o <= level_for(phase_i);
      wrap_o      <= adv_d && (phase_i == '0);
    end
  end

  // R1: reset leaves every line floating and the strobe low
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (line_en_o == '0 && drive_lvl_o && !wrap_o));

  // R4: never more than one line driven
  p_one_line_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(line_en_o));

  // R3: the level flips only at a zero sample
  p_level_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (drive_lvl_o != $past(drive_lvl_o)) |-> (line_en_o == '0));

  // R9: the strobe is a single cycle
  p_wrap_single_r9: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

  // R9: the strobe coincides with the positive zero sample
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (line_en_o == '0 && drive_lvl_o));
endmodule

// File: rtl/fsk_tristate_sequencer.sv
module fsk_tristate_sequencer #(
  parameter int CLK_HZ   = 250_000_000,
  parameter int MARK_HZ  = 1200,
  parameter int SPACE_HZ = 2200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       data_i,
  output logic [2:0] line_en_o,
  output logic       drive_lvl_o,
  output logic       wrap_o
);
  import fsk_seq_pkg::*;

  localparam int MARK_RAW  = (CLK_HZ + (STEPS / 2) * MARK_HZ)  / (STEPS * MARK_HZ);
  localparam int SPACE_RAW = (CLK_HZ + (STEPS / 2) * SPACE_HZ) / (STEPS * SPACE_HZ);
  localparam int MARK_RELOAD  = (MARK_RAW  < 2) ? 2 : MARK_RAW;
  localparam int SPACE_RELOAD = (SPACE_RAW < 2) ? 2 : SPACE_RAW;
  localparam int MAX_RELOAD   = (MARK_RELOAD > SPACE_RELOAD) ? MARK_RELOAD : SPACE_RELOAD;
  localparam int CNT_W        = $clog2(MAX_RELOAD + 1);

  logic   step_adv;
  phase_t phase;

  fsk_step_timer #(
    .MARK_RELOAD  (MARK_RELOAD),
    .SPACE_RELOAD (SPACE_RELOAD),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .data_i     (data_i),
    .step_adv_o (step_adv)
  );

  fsk_phase_walk u_walk (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (step_adv),
    .phase_o (phase)
  );

  fsk_line_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase),
    .adv_i       (step_adv),
    .line_en_o   (line_en_o),
    .drive_lvl_o (drive_lvl_o),
    .wrap_o      (wrap_o)
  );
endmodule

// File: tb/sim_fsk_tristate_sequencer.sv
`timescale 1ns/1ps
module sim_fsk_tristate_sequencer;
  localparam int CLK_HZ = 273600;
  localparam int RM = 19;   // mark step length
  localparam int RS = 10;   // space step length

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data = 1'b1;
  logic [2:0] en;
  logic lvl, wrap;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fsk_tristate_sequencer #(.CLK_HZ(CLK_HZ), .MARK_HZ(1200), .SPACE_HZ(2200)) u0 (
    .clk(clk), .rst(rst), .data_i(data),
    .line_en_o(en), .drive_lvl_o(lvl), .wrap_o(wrap)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles until the outputs show a different step
  task automatic next_step(output int len);
    logic [3:0] cur;
    cur = {en, lvl};
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while ({en, lvl} == cur && len < 1000);
  endtask

  // cycles until the next strobe
  task automatic wait_wrap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wrap && n < 5000);
  endtask

  // R4 monitored every cycle
  int multi_drive = 0;
  always @(negedge clk) if (!rst && (en & (en - 3'd1)) != 3'd0) multi_drive++;

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 enables in reset", int'(en), 0);
    check("R1 level in reset", int'(lvl), 1);
    check("R1 strobe in reset", int'(wrap), 0);
  endtask

  task automatic t_sequence;
    int n, len;
    logic [2:0] exp_en [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b010, 3'b001};
    data = 1'b1;
    wait_wrap(n);
    for (int s = 0; s < 12; s++) begin
      if (s < 6) begin
        check($sformatf("R2 enables step %0d", s), int'(en), int'(exp_en[s]));
        check($sformatf("R2 level step %0d", s), int'(lvl), 1);
      end else begin
        check($sformatf("R3 enables step %0d", s), int'(en), int'(exp_en[s-6]));
        check($sformatf("R3 level step %0d", s), int'(lvl), 0);
      end
      next_step(len);
    end
    check("R2 wrap after 12 steps", int'(wrap), 1);
  endtask

  task automatic t_tone(input logic d, input int r, input string req);
    int n, len;
    data = d;
    wait_wrap(n);
    wait_wrap(n);
    wait_wrap(n);
    check({req, " cycle length"}, n, 12 * r);
    next_step(len);
    check({req, " step length"}, len, r);
    check("R9 strobe single cycle", int'(wrap), 0);
  endtask

  task automatic t_midstep_change;
    int n, len, l2;
    logic [2:0] en_before;
    logic lvl_before;
    data = 1'b1;
    wait_wrap(n);
    wait_wrap(n);
    next_step(len);  // now at start of step 1
    next_step(len);  // now at start of step 2
    en_before = en;
    lvl_before = lvl;
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (len == 4) data = 1'b0;
    end while ({en, lvl} == {en_before, lvl_before} && len < 1000);
    check("R7 current step keeps old length", len, RM);
    check("R7 phase continues to step 3", int'(en), 4);
    check("R7 level unchanged", int'(lvl), 1);
    next_step(l2);
    check("R7 next step uses new length", l2, RS);
    check("R7 then step 4 pattern", int'(en), 2);
  endtask

  task automatic t_reset_mid;
    int len, n;
    data = 1'b0;
    wait_wrap(n);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    data = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    len = 0;
    n = 0;
    do begin
      @(negedge clk);
      len++;
      if (wrap) n++;
    end while (en == 3'b000 && len < 1000);
    check("R8 first step length after reset", len, RM + 1);
    check("R9 no strobe at reset release", n, 0);
    check("R8 second step is 30 deg line", int'(en), 1);
    next_step(len);
    check("R8 second step length", len, RM);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 enables after release", int'(en), 0);
    t_sequence();
    t_tone(1'b1, RM, "R5");
    t_tone(1'b0, RS, "R6");
    t_midstep_change();
    t_reset_mid();
    check("R4 at most one line per cycle", multi_drive, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule